// File: doc/BRIEF.md
# Two-Wire Bus Conditioner and Condition Detector

This block is the oversampled receive and transmit edge of a two-wire bus slave. The raw clock line and data line are sampled by a fast system clock. Each line passes through a short synchronizer chain and then a counting glitch filter. Only the filtered levels are used to find bus events. These events are the rising and falling edges of the bus clock, the data level latched at each clock rise, and the two framing conditions. START is the data line falling while the bus clock is high. STOP is the data line rising while the bus clock is high.

On the transmit side, the block takes the level that the byte engine wants on the data line. After each detected falling edge of the bus clock, it holds its own pull-down output unchanged for a fixed number of system clocks. A data change made by the slave therefore always lands well inside the clock-low phase. It can never be seen as a framing condition. The filter length and the hold length are derived from the system clock period, the spike width to reject and the minimum hold time. Byte assembly, addressing and acknowledge generation belong to the next block.

Top module: `twb_front_end`

## Requirements
- R1: While reset is held and in the cycle after it is released, all four strobes are 0, `data_bit` is 0, `bus_idle` is 1 and `sda_pull_low` is 0.
- R2: When the filtered data line falls while the filtered bus clock is high, `start_det` pulses for exactly one cycle, and `bus_idle` is 0 from the next cycle.
- R3: When the filtered data line rises while the filtered bus clock is high, `stop_det` pulses for exactly one cycle, and `bus_idle` is 1 from the next cycle.
- R4: Each rising edge of the filtered bus clock gives one single-cycle `scl_rise` pulse, and each falling edge gives one `scl_fall` pulse. In the cycle of `scl_rise`, `data_bit` shows the filtered data level, and it keeps that value until the next `scl_rise`.
- R5: Data line changes made while the bus clock is low produce no `start_det` or `stop_det`.
- R6: A pulse on either input that lasts fewer than FILT_CYCLES system clocks produces no strobe at all. FILT_CYCLES is SPIKE_NS/CLK_NS + 1, which is 6 with the defaults, so pulses of 50 ns or less are dropped. A pulse of FILT_CYCLES clocks or more is accepted.
- R7: When the bus clock falls in the same filtered cycle as the data line changes, the framing condition is reported and `scl_fall` is suppressed for that edge.
- R8: After an `scl_fall` pulse, `sda_pull_low` keeps its previous value for at least HOLD_CYCLES system clocks. HOLD_CYCLES is HOLD_NS/CLK_NS rounded up, which is 30 with the defaults. It then takes the requested level within HOLD_CYCLES+2 clocks of the pulse.
- R9: When no hold is running, `sda_pull_low` becomes the inverse of `tx_sda_release` one cycle after the request changes. 1 on `sda_pull_low` means the line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| tx_sda_release | input | 1 | Requested data level from the byte engine; 0 asks to pull the line low |
| scl_rise | output | 1 | One-cycle strobe on a filtered bus clock rise |
| scl_fall | output | 1 | One-cycle strobe on a filtered bus clock fall |
| start_det | output | 1 | One-cycle strobe on a START condition |
| stop_det | output | 1 | One-cycle strobe on a STOP condition |
| data_bit | output | 1 | Data level captured at the last bus clock rise |
| bus_idle | output | 1 | 1 from reset or STOP until the next START |
| sda_pull_low | output | 1 | Open-drain enable for the data line, delayed after clock falls |

## Verification
The bench builds the block with the default parameters: a 10 ns system clock, 50 ns spike rejection and 300 ns hold. This gives a filter of 6 clocks and a hold of 30 clocks. Spikes of 5 and 6 clocks are therefore placed exactly on either side of the acceptance boundary. The hold window can be timed to the clock against the HOLD_CYCLES bound. These values also make the coincident clock-fall and data-change case reachable, because both lines pass through pipelines of identical length.

// File: rtl/twb_pkg.sv
// Package twb_pkg
// Shared helpers and types for the two-wire bus front end.
// Assumes all time values are given as whole nanoseconds.
package twb_pkg;

    // Pair of bus line levels, used for the raw and the filtered views.
    typedef struct packed {
        logic scl;
        logic sda;
    } twb_lines_t;

    // Integer division rounded up; used to turn a time into a cycle count.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/twb_line_filter.sv
// Module twb_line_filter
// Brings one asynchronous bus line into the clock domain through a
// SYNC_STAGES-flop chain. It then accepts a new level only after that
// level has been seen for FILT_CYCLES consecutive clocks.
// Assumes the line rests high (pulled up) when nobody drives it.
module twb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_filt
);
    localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   line_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_raw};
    end

    // Count how long the synchronized level has differed; flip when long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            line_q  <= 1'b1;
        end else if (sync_q[SYNC_STAGES-1] == line_q) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            run_cnt <= '0;
            line_q  <= sync_q[SYNC_STAGES-1];
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign line_filt = line_q;
endmodule

// File: rtl/twb_cond_detect.sv
// Module twb_cond_detect
// Finds clock edges and framing conditions on the filtered lines and
// registers them as one-cycle strobes. A framing condition outranks a
// clock edge seen in the same cycle. The module also latches the data
// level at each clock rise and tracks whether a transfer is open.
// Assumes both inputs are already synchronous and glitch-free.
module twb_cond_detect (
    input  logic              clk,
    input  logic              rst_n,
    input  twb_pkg::twb_lines_t lines,
    output logic              scl_rise,
    output logic              scl_fall,
    output logic              start_det,
    output logic              stop_det,
    output logic              data_bit,
    output logic              bus_idle
);
    logic scl_q, sda_q, busy_q;
    logic sda_fell, sda_rose, start_c, stop_c, frame_c, rise_c, fall_c;

    // Classify the current cycle from the previous and the present levels.
    always_comb begin
        sda_fell = sda_q & ~lines.sda;
        sda_rose = ~sda_q & lines.sda;
        start_c  = scl_q & sda_fell;
        stop_c   = scl_q & sda_rose;
        frame_c  = start_c | stop_c;
        rise_c   = ~scl_q & lines.scl & ~frame_c;
        fall_c   = scl_q & ~lines.scl & ~frame_c;
    end

    // Keep the previous levels and register the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            scl_rise  <= 1'b0;
            scl_fall  <= 1'b0;
            start_det <= 1'b0;
            stop_det  <= 1'b0;
        end else begin
            scl_q     <= lines.scl;
            sda_q     <= lines.sda;
            scl_rise  <= rise_c;
            scl_fall  <= fall_c;
            start_det <= start_c;
            stop_det  <= stop_c;
        end
    end

    // Capture the data level on each clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_bit <= 1'b0;
        else if (rise_c) data_bit <= lines.sda;
    end

    // Open a transfer on START and close it on STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy_q <= 1'b0;
        else if (start_c) busy_q <= 1'b1;
        else if (stop_c)  busy_q <= 1'b0;
    end

    assign bus_idle = ~busy_q;
endmodule

// File: rtl/twb_sda_hold.sv
// Module twb_sda_hold
// Owns the open-drain enable for the data line. Every clock-fall strobe
// freezes the current drive for HOLD_CYCLES clocks. Outside that window
// the drive follows the requested level one clock later.
// Assumes the requester only asks for changes while the bus clock is low.
module twb_sda_hold #(
    parameter int HOLD_CYCLES = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_fall,
    input  logic tx_sda_release,
    output logic sda_pull_low
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] LOAD = HW'(HOLD_CYCLES);

    logic [HW-1:0] hold_cnt;
    logic          release_q;

    // Restart the hold on a clock fall; otherwise count down, then follow the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt  <= '0;
            release_q <= 1'b1;
        end else if (scl_fall) begin
            hold_cnt  <= LOAD;
        end else if (hold_cnt != '0) begin
            hold_cnt  <= hold_cnt - 1'b1;
        end else begin
            release_q <= tx_sda_release;
        end
    end

    assign sda_pull_low = ~release_q;
endmodule

// File: rtl/twb_front_end.sv
// Module twb_front_end
// Top of the two-wire bus front end: two line filters, the condition
// detector and the transmit hold. Cycle counts come from the system clock
// period so the same code serves any oversampling rate.
// Assumes CLK_NS is well below the bus clock low and high times.
module twb_front_end #(
    parameter int CLK_NS      = 10,
    parameter int SPIKE_NS    = 50,
    parameter int HOLD_NS     = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic tx_sda_release,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic data_bit,
    output logic bus_idle,
    output logic sda_pull_low
);
    import twb_pkg::*;

    localparam int FILT_CYCLES = SPIKE_NS / CLK_NS + 1;
    localparam int HOLD_CYCLES = ceil_div(HOLD_NS, CLK_NS);
    localparam int NLINES      = 2;

    logic [NLINES-1:0] raw_vec, filt_vec;
    twb_lines_t        filt;

    assign raw_vec = {scl_in, sda_in};

    // One identical filter per line so both lines see the same latency.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        twb_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_CYCLES (FILT_CYCLES)
        ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_raw  (raw_vec[g]),
            .line_filt (filt_vec[g])
        );
    end

    assign filt = twb_lines_t'(filt_vec);

    twb_cond_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines     (filt),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .data_bit  (data_bit),
        .bus_idle  (bus_idle)
    );

    twb_sda_hold #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_fall       (scl_fall),
        .tx_sda_release (tx_sda_release),
        .sda_pull_low   (sda_pull_low)
    );
endmodule

// File: rtl/twb_front_end_chk.sv
// Module twb_front_end_chk
// Property checker attached to twb_front_end. It watches the ports only.
// The hold window is measured by a local counter, not by a long delay.
module twb_front_end_chk #(
    parameter int HOLD_CYCLES = 30
) (
    input logic clk,
    input logic rst_n,
    input logic scl_rise,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic data_bit,
    input logic bus_idle,
    input logic sda_pull_low
);
    logic [15:0] since_fall;
    logic        armed;

    // Count clocks since the last clock-fall strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_fall <= '0;
            armed      <= 1'b0;
        end else if (scl_fall) begin
            since_fall <= '0;
            armed      <= 1'b1;
        end else if (since_fall != 16'hFFFF) begin
            since_fall <= since_fall + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!scl_rise && !scl_fall && !start_det && !stop_det && bus_idle && !sda_pull_low));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !bus_idle);

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !start_det);

    assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> bus_idle);

    assert_edge_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall}));

    assert_bit_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_rise |=> (scl_rise || $stable(data_bit)));

    assert_frame_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> (!scl_rise && !scl_fall));

    assert_hold_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> $stable(sda_pull_low));

    assert_hold_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !scl_fall && since_fall < 16'(HOLD_CYCLES - 1)) |=> $stable(sda_pull_low));
endmodule

bind twb_front_end twb_front_end_chk #(
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .data_bit     (data_bit),
    .bus_idle     (bus_idle),
    .sda_pull_low (sda_pull_low)
);

// File: tb/twb_front_end_tb.sv
// Scoreboard bench for twb_front_end. Driver tasks queue the strobes each
// bus action must produce; a monitor pops and compares them as they appear.
module twb_front_end_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 50 / CLK_PERIOD + 1;
    localparam int HOLD       = (300 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int PH         = 20;

    // Event codes: 1 START, 2 STOP, 3 rise with bit 0, 4 rise with bit 1, 5 fall
    localparam int EV_START = 1, EV_STOP = 2, EV_RISE0 = 3, EV_RISE1 = 4, EV_FALL = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_r = 1'b1, sda_r = 1'b1, tx_rel = 1'b1;
    logic scl_rise, scl_fall, start_det, stop_det, data_bit, bus_idle, sda_pull_low;

    int compared = 0;
    int mismatched = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twb_front_end u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_in         (scl_r),
        .sda_in         (sda_r),
        .tx_sda_release (tx_rel),
        .scl_rise       (scl_rise),
        .scl_fall       (scl_fall),
        .start_det      (start_det),
        .stop_det       (stop_det),
        .data_bit       (data_bit),
        .bus_idle       (bus_idle),
        .sda_pull_low   (sda_pull_low)
    );

    function automatic string tag_of(input int code);
        case (code)
            EV_START: return "R2";
            EV_STOP:  return "R3";
            default:  return "R4";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: turn each strobe cycle into a code and compare with the queue head.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int n, code;
            n = int'(scl_rise) + int'(scl_fall) + int'(start_det) + int'(stop_det);
            code = 0;
            if (n > 1)          code = 9;
            else if (start_det) code = EV_START;
            else if (stop_det)  code = EV_STOP;
            else if (scl_rise)  code = data_bit ? EV_RISE1 : EV_RISE0;
            else if (scl_fall)  code = EV_FALL;
            if (code != 0) begin
                if (exp_q.size() == 0) begin
                    check("R5/R6 unexpected strobe", code, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(tag_of(e), code, e);
                end
            end
        end
    end

    task automatic do_start();
        exp_q.push_back(EV_START); sda_r = 1'b0; wait_cyc(PH);
        exp_q.push_back(EV_FALL);  scl_r = 1'b0; wait_cyc(PH);
    endtask

    task automatic send_bit(input logic b);
        sda_r = b; wait_cyc(PH);
        exp_q.push_back(b ? EV_RISE1 : EV_RISE0); scl_r = 1'b1; wait_cyc(PH);
        exp_q.push_back(EV_FALL); scl_r = 1'b0; wait_cyc(PH);
    endtask

    task automatic do_stop();
        sda_r = 1'b0; wait_cyc(PH);
        exp_q.push_back(EV_RISE0); scl_r = 1'b1; wait_cyc(PH);
        exp_q.push_back(EV_STOP);  sda_r = 1'b1; wait_cyc(PH);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int n;
        wait_cyc(4);
        // R1: reset state seen while reset is held
        check("R1 strobes", int'(scl_rise | scl_fall | start_det | stop_det), 0);
        check("R1 idle", int'(bus_idle), 1);
        check("R1 pull", int'(sda_pull_low), 0);
        check("R1 data_bit", int'(data_bit), 0);
        rst_n = 1'b1;
        wait_cyc(PH);

        // R9: no hold pending, drive follows request one cycle later
        tx_rel = 1'b0; wait_cyc(1);
        check("R9 pull on", int'(sda_pull_low), 1);
        tx_rel = 1'b1; wait_cyc(1);
        check("R9 pull off", int'(sda_pull_low), 0);

        // R2: START opens a transfer
        do_start();
        check("R2 busy", int'(bus_idle), 0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);

        // R5: data toggles with clock low give no framing strobe
        sda_r = 1'b0; wait_cyc(PH); sda_r = 1'b1; wait_cyc(PH);
        sda_r = 1'b0; wait_cyc(PH); sda_r = 1'b1; wait_cyc(PH);
        check("R5 queue drained", exp_q.size(), 0);
        check("R5 still busy", int'(bus_idle), 0);

        // R6: clock spike of FILT-1 cycles dropped, FILT cycles accepted
        scl_r = 1'b1; wait_cyc(FILT - 1); scl_r = 1'b0; wait_cyc(PH);
        exp_q.push_back(EV_RISE1); exp_q.push_back(EV_FALL);
        scl_r = 1'b1; wait_cyc(FILT); scl_r = 1'b0; wait_cyc(PH);
        check("R6 queue drained", exp_q.size(), 0);

        // R6: short data spike with clock high gives no START or STOP
        exp_q.push_back(EV_RISE1); scl_r = 1'b1; wait_cyc(PH);
        sda_r = 1'b0; wait_cyc(FILT - 1); sda_r = 1'b1; wait_cyc(PH);
        check("R6 data spike", int'(bus_idle), 0);
        exp_q.push_back(EV_FALL); scl_r = 1'b0; wait_cyc(PH);

        // R8: drive frozen for the hold window after a clock fall
        sda_r = 1'b0; wait_cyc(PH);
        exp_q.push_back(EV_RISE0); scl_r = 1'b1; wait_cyc(PH);
        exp_q.push_back(EV_FALL);  scl_r = 1'b0;
        n = 0;
        while (!scl_fall && n < 200) begin wait_cyc(1); n++; end
        tx_rel = 1'b0;
        n = 0;
        while (!sda_pull_low && n < 200) begin wait_cyc(1); n++; end
        check("R8 hold min", int'(n >= HOLD + 1), 1);
        check("R8 hold max", int'(n <= HOLD + 2), 1);
        wait_cyc(PH);
        tx_rel = 1'b1; wait_cyc(2);
        check("R9 release", int'(sda_pull_low), 0);

        // R3: STOP closes the transfer
        do_stop();
        check("R3 idle", int'(bus_idle), 1);

        // R7: clock fall and data fall in the same cycle report START only
        exp_q.push_back(EV_START);
        scl_r = 1'b0; sda_r = 1'b0; wait_cyc(PH);
        check("R7 busy", int'(bus_idle), 0);
        check("R7 queue drained", exp_q.size(), 0);
        send_bit(1'b0);
        do_stop();
        check("R3 idle again", int'(bus_idle), 1);

        wait_cyc(PH);
        check("R4 all events seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule